// File: doc/BRIEF.md
# Asynchronous Memory-Bus to Byte-Register Bridge

This block is a slave on an asynchronous external memory bus. It turns each external access into one or two single-cycle strobes on an internal bank of 8-bit registers with 7-bit addresses. The active-low chip-select, output-enable and write-enable lines pass through a two-stage synchroniser. A falling edge of output-enable or write-enable, seen while chip-select is low, starts exactly one transaction. Address, byte enables, write data and the two strap inputs are sampled when that edge is detected. By then they have been stable for the whole setup time.

One strap picks the external bus width and the other picks the byte order. With a 16-bit bus, the 6-bit word address and the byte lane together form the register address, and the byte-order strap decides which lane holds the even register. With an 8-bit bus, the bank input supplies the low register address bit and all data uses the lower lane. Every read is preceded by a one-cycle freeze pulse, so that a register group can snapshot its value before it is read. The wait output stays high while the internal strobes are in flight.

Top module: `async_reg_bridge`

## Requirements
- R1: After reset, extWait, regRd, regWr and regFreeze are 0 and extDout is 0.
- R2: A falling edge of extOeN (read) or extWeN (write) while extCsN is low starts exactly one transaction, however long the strobe is held. Strobe edges while extCsN is high cause no internal strobe and leave extDout unchanged.
- R3: A 16-bit read (wide16=1) fetches both bytes. Lane L (L=0 is extDout[7:0], L=1 is extDout[15:8]) comes from register address {extAddr, L XOR bigEnd}. Lane 0 is read first, giving 2 regRd pulses. Byte enables do not affect reads.
- R4: A 16-bit write issues one regWr per set byte enable. extBe[0] writes extDin[7:0] to {extAddr, bigEnd}, and extBe[1] writes extDin[15:8] to {extAddr, NOT bigEnd}. With no byte enable set, nothing is written.
- R5: In 8-bit mode (wide16=0) every access is a single transfer at address {extAddr, extBank} through extDin[7:0] or extDout[7:0], and byte enables are ignored. A read drives extDout[15:8] with 0.
- R6: regFreeze is high for exactly one cycle, the cycle directly before the first regRd of a read. Writes never raise it.
- R7: extWait is high in the 3rd clock cycle after the strobe falls and low by the 5th. Read data is complete on extDout from then until the strobe ends.
- R8: Accesses with 2 cycles setup, 7 cycles strobe, 1 cycle hold and 1 cycle turnaround, issued back to back, are all served correctly.
- R9: regRd and regWr are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extAddr | input | 6 | External word address |
| extBank | input | 1 | Low address bit in 8-bit mode |
| extBe | input | 2 | Byte-lane enables, active high |
| extCsN | input | 1 | Chip select, active low |
| extOeN | input | 1 | Read strobe, active low |
| extWeN | input | 1 | Write strobe, active low |
| extDin | input | 16 | External write data |
| extDout | output | 16 | External read data |
| extWait | output | 1 | Wait request to the master |
| wide16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| bigEnd | input | 1 | 1 = even register on the upper lane |
| regAddr | output | 7 | Register address |
| regWdata | output | 8 | Register write data |
| regRdata | input | 8 | Register read data, valid in the regRd cycle |
| regRd | output | 1 | Register read strobe |
| regWr | output | 1 | Register write strobe |
| regFreeze | output | 1 | Snapshot request ahead of a read |

## Verification
The bench sweeps both widths, both byte orders, every byte-enable pattern and the edge word addresses. It writes through the bridge and reads back, and every access uses the minimum timing. A swapped endian mapping would put register bytes on the wrong lane or at the wrong address. A design that ignored byte enables would corrupt neighbouring registers, and one that left the upper lane undriven in 8-bit mode would show stale data. Freeze placement, the number of strobes per access and the sampling point of wait are counted on every access, which catches a late freeze, duplicate transactions from a held strobe, and wait released too late for a 7-cycle strobe.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LANE0,
    ST_LANE1,
    ST_DONE
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // sample address, data and straps
    logic clr;      // clear output bytes at read start
    logic laneSel;  // lane being served
    logic cap;      // capture read byte of laneSel
  } dpStrobe_t;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= RST_VAL;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       oeN,
  input  logic       weN,
  input  logic [1:0] beIn,
  input  logic       wide16,
  output dpStrobe_t  strb,
  output logic       regRd,
  output logic       regWr,
  output logic       regFreeze,
  output logic       extWait
);

  logic [2:0] syncOut;
  logic csS, oeS, weS;
  logic oePrev, wePrev;
  logic rdFall, wrFall, startRd, startWr;
  ctlState_e state, stateNext;
  logic isReadQ;
  logic [1:0] laneEnQ;
  logic laneActive;

  arb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, oeN, weN}),
    .dout(syncOut)
  );
  assign {csS, oeS, weS} = syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oePrev <= 1'b1;
      wePrev <= 1'b1;
    end else begin
      oePrev <= oeS;
      wePrev <= weS;
    end
  end

  assign rdFall  = oePrev & ~oeS & ~csS;
  assign wrFall  = wePrev & ~weS & ~csS;
  assign startWr = wrFall;
  assign startRd = rdFall & ~wrFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isReadQ <= 1'b0;
      laneEnQ <= 2'b00;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && (startRd || startWr)) begin
        isReadQ <= startRd;
        if (startRd) laneEnQ <= wide16 ? 2'b11 : 2'b01;
        else         laneEnQ <= wide16 ? beIn  : 2'b01;
      end
    end
  end

  assign laneActive = (state == ST_LANE0) ? laneEnQ[0] :
                      (state == ST_LANE1) ? laneEnQ[1] : 1'b0;

  always_comb begin
    stateNext = state;
    strb      = '0;
    regFreeze = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startRd || startWr) begin
          strb.latch = 1'b1;
          strb.clr   = startRd;
          regFreeze  = startRd;
          stateNext  = ST_LANE0;
        end
      end
      ST_LANE0: begin
        strb.laneSel = 1'b0;
        strb.cap     = isReadQ & laneActive;
        stateNext    = ST_LANE1;
      end
      ST_LANE1: begin
        strb.laneSel = 1'b1;
        strb.cap     = isReadQ & laneActive;
        stateNext    = ST_DONE;
      end
      ST_DONE: begin
        if (oeS && weS) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign regRd   = laneActive & isReadQ;
  assign regWr   = laneActive & ~isReadQ;
  assign extWait = (state == ST_LANE0) || (state == ST_LANE1);

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && regWr)); // R9

  AST_FRZ_THEN_READ: assert property (@(posedge clk) disable iff (!rstN)
    regFreeze |=> regRd); // R6

  AST_FRZ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regFreeze |=> !regFreeze); // R6

  AST_WAIT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (extWait && $past(extWait)) |=> !extWait); // R7

  AST_WR_NO_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> !$past(regFreeze)); // R6

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int WORD_AW = 6,
  parameter int BYTE_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [WORD_AW-1:0]    wordAddr,
  input  logic                  bank,
  input  logic [2*BYTE_W-1:0]   din,
  input  logic                  wide16,
  input  logic                  bigEnd,
  input  logic [BYTE_W-1:0]     regRdata,
  output logic [WORD_AW:0]      regAddr,
  output logic [BYTE_W-1:0]     regWdata,
  output logic [2*BYTE_W-1:0]   extDout
);

  localparam int LANES = 2;

  logic [WORD_AW-1:0]  wordQ;
  logic                bankQ, wideQ, bigQ;
  logic [2*BYTE_W-1:0] dinQ;
  logic                laneIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      bankQ <= 1'b0;
      wideQ <= 1'b0;
      bigQ  <= 1'b0;
      dinQ  <= '0;
    end else if (strb.latch) begin
      wordQ <= wordAddr;
      bankQ <= bank;
      wideQ <= wide16;
      bigQ  <= bigEnd;
      dinQ  <= din;
    end
  end

  // narrow bus always uses the lower lane
  assign laneIdx  = wideQ & strb.laneSel;
  assign regAddr  = {wordQ, wideQ ? (strb.laneSel ^ bigQ) : bankQ};
  assign regWdata = dinQ[laneIdx*BYTE_W +: BYTE_W];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (strb.clr) begin
        laneQ <= '0;
      end else if (strb.cap && (laneIdx == 1'(g))) begin
        laneQ <= regRdata;
      end
    end
    assign extDout[g*BYTE_W +: BYTE_W] = laneQ;
  end

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cap && !strb.clr) |=> $stable(extDout)); // R7

endmodule

// File: rtl/async_reg_bridge.sv
module async_reg_bridge
  import arb_pkg::*;
#(
  parameter int WORD_AW     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_AW-1:0] extAddr,
  input  logic               extBank,
  input  logic [1:0]         extBe,
  input  logic               extCsN,
  input  logic               extOeN,
  input  logic               extWeN,
  input  logic [15:0]        extDin,
  output logic [15:0]        extDout,
  output logic               extWait,
  input  logic               wide16,
  input  logic               bigEnd,
  output logic [WORD_AW:0]   regAddr,
  output logic [7:0]         regWdata,
  input  logic [7:0]         regRdata,
  output logic               regRd,
  output logic               regWr,
  output logic               regFreeze
);

  dpStrobe_t strb;

  arb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (extCsN),
    .oeN      (extOeN),
    .weN      (extWeN),
    .beIn     (extBe),
    .wide16   (wide16),
    .strb     (strb),
    .regRd    (regRd),
    .regWr    (regWr),
    .regFreeze(regFreeze),
    .extWait  (extWait)
  );

  arb_datapath #(.WORD_AW(WORD_AW), .BYTE_W(8)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wordAddr(extAddr),
    .bank    (extBank),
    .din     (extDin),
    .wide16  (wide16),
    .bigEnd  (bigEnd),
    .regRdata(regRdata),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .extDout (extDout)
  );

endmodule

// File: tb/async_reg_bridge_tb_top.sv
module async_reg_bridge_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic [5:0]  extAddr;
  logic        extBank;
  logic [1:0]  extBe;
  logic        extCsN, extOeN, extWeN;
  logic [15:0] extDin, extDout;
  logic        extWait, wide16, bigEnd;
  logic [6:0]  regAddr;
  logic [7:0]  regWdata, regRdata;
  logic        regRd, regWr, regFreeze;

  async_reg_bridge dut_i (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .extBank(extBank), .extBe(extBe),
    .extCsN(extCsN), .extOeN(extOeN), .extWeN(extWeN), .extDin(extDin),
    .extDout(extDout), .extWait(extWait), .wide16(wide16), .bigEnd(bigEnd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRd(regRd), .regWr(regWr), .regFreeze(regFreeze)
  );

  // register bank stub
  logic [7:0] bankMem [0:127];
  logic [7:0] expMem  [0:127];
  assign regRdata = bankMem[regAddr];

  int rdCnt = 0, wrCnt = 0, frzCnt = 0, rdAfterFrz = 0, bothCnt = 0;
  bit frzPrev = 1'b0;

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) bankMem[i] <= 8'(i * 37 + 5);
      frzPrev = 1'b0;
    end else begin
      if (regRd) begin
        rdCnt++;
        if (frzPrev) rdAfterFrz++;
      end
      if (regWr) begin
        wrCnt++;
        bankMem[regAddr] <= regWdata;
      end
      if (regFreeze) frzCnt++;
      if (regRd && regWr) bothCnt++;
      frzPrev = regFreeze;
    end
  end

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit rd, input bit wide, input bit big,
                        input logic [5:0] w, input bit bk, input logic [1:0] be,
                        input logic [15:0] din,
                        output logic [15:0] d5, output logic [15:0] d7,
                        output bit w3, output bit w5);
    extAddr = w; extBank = bk; extBe = be; extDin = din;
    wide16 = wide; bigEnd = big; extCsN = 1'b0;
    repeat (2) @(negedge clk);
    if (rd) extOeN = 1'b0; else extWeN = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 3) w3 = extWait;
      if (k == 5) begin w5 = extWait; d5 = extDout; end
      if (k == 7) d7 = extDout;
    end
    extOeN = 1'b1; extWeN = 1'b1;
    @(negedge clk); extCsN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doRead(input bit wide, input bit big, input logic [5:0] w, input bit bk);
    logic [15:0] d5, d7, expD;
    bit w3, w5;
    int r0, f0, a0, wr0;
    if (wide) expD = {expMem[{w, ~big}], expMem[{w, big}]};   // R3
    else      expD = {8'h00, expMem[{w, bk}]};                 // R5
    r0 = rdCnt; f0 = frzCnt; a0 = rdAfterFrz; wr0 = wrCnt;
    access(1'b1, wide, big, w, bk, 2'b00, 16'hFFFF, d5, d7, w3, w5);
    chk(d5 == expD, wide ? "R3" : "R5", "read data at strobe cycle 5", d5, expD);
    chk(d7 == expD, "R7", "read data held to strobe end", d7, expD);
    chk(w3 == 1'b1, "R7", "wait high in cycle 3", w3, 1);
    chk(w5 == 1'b0, "R7", "wait low by cycle 5", w5, 0);
    chk(rdCnt - r0 == (wide ? 2 : 1), "R2", "read strobes per access", rdCnt - r0, wide ? 2 : 1);
    chk(wrCnt == wr0, "R9", "no write on read", wrCnt - wr0, 0);
    chk(frzCnt - f0 == 1, "R6", "one freeze per read", frzCnt - f0, 1);
    chk(rdAfterFrz - a0 == 1, "R6", "freeze just before first read", rdAfterFrz - a0, 1);
  endtask

  task automatic doWrite(input bit wide, input bit big, input logic [5:0] w, input bit bk,
                         input logic [1:0] be, input logic [15:0] din);
    logic [15:0] d5, d7;
    bit w3, w5, same;
    int r0, f0, wr0, expN;
    if (wide) begin
      if (be[0]) expMem[{w, big}]  = din[7:0];    // R4
      if (be[1]) expMem[{w, ~big}] = din[15:8];   // R4
      expN = int'(be[0]) + int'(be[1]);
    end else begin
      expMem[{w, bk}] = din[7:0];                 // R5
      expN = 1;
    end
    r0 = rdCnt; f0 = frzCnt; wr0 = wrCnt;
    access(1'b0, wide, big, w, bk, be, din, d5, d7, w3, w5);
    chk(wrCnt - wr0 == expN, wide ? "R4" : "R5", "write strobes", wrCnt - wr0, expN);
    chk(rdCnt == r0, "R9", "no read on write", rdCnt - r0, 0);
    chk(frzCnt == f0, "R6", "no freeze on write", frzCnt - f0, 0);
    chk(w3 == 1'b1 && w5 == 1'b0, "R7", "wait window on write", {w3, w5}, 2'b10);
    same = 1'b1;
    for (int i = 0; i < 128; i++) if (bankMem[i] !== expMem[i]) same = 1'b0;
    chk(same, wide ? "R4" : "R5", "register bank contents", same, 1);
  endtask

  initial begin
    logic [5:0] words [4];
    logic [15:0] keep;
    int r0, w0, f0;
    words[0] = 6'd0; words[1] = 6'd21; words[2] = 6'd42; words[3] = 6'd63;
    for (int i = 0; i < 128; i++) expMem[i] = 8'(i * 37 + 5);
    rstN = 1'b0; extAddr = '0; extBank = 1'b0; extBe = 2'b00;
    extCsN = 1'b1; extOeN = 1'b1; extWeN = 1'b1; extDin = '0;
    wide16 = 1'b1; bigEnd = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(extWait == 1'b0, "R1", "wait after reset", extWait, 0);
    chk(extDout == 16'h0, "R1", "dout after reset", extDout, 0);
    chk({regRd, regWr, regFreeze} == 3'b000, "R1", "strobes after reset",
        {regRd, regWr, regFreeze}, 0);

    // R8: every access below uses minimum setup/strobe/hold/turnaround
    for (int wd = 0; wd < 2; wd++)
      for (int bg = 0; bg < 2; bg++)
        for (int wi = 0; wi < 4; wi++) begin
          doRead(wd[0], bg[0], words[wi], 1'b0);
          for (int be = 0; be < 4; be++) begin
            doWrite(wd[0], bg[0], words[wi], be[0], be[1:0],
                    16'(words[wi] * 151 + be * 29 + bg * 7 + wd * 3 + 16'h5A00));
            doRead(wd[0], bg[0], words[wi], 1'b0);
            doRead(wd[0], bg[0], words[wi], 1'b1);
          end
        end

    // R2: strobes with chip select high are ignored
    keep = extDout;
    r0 = rdCnt; w0 = wrCnt; f0 = frzCnt;
    extCsN = 1'b1; extAddr = 6'd5;
    repeat (2) @(negedge clk);
    extOeN = 1'b0; repeat (7) @(negedge clk); extOeN = 1'b1;
    repeat (2) @(negedge clk);
    extWeN = 1'b0; repeat (7) @(negedge clk); extWeN = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdCnt == r0 && wrCnt == w0 && frzCnt == f0, "R2", "strobes with cs high",
        (rdCnt - r0) + (wrCnt - w0) + (frzCnt - f0), 0);
    chk(extDout == keep, "R2", "dout unchanged with cs high", extDout, keep);
    doRead(1'b1, 1'b0, 6'd5, 1'b0);

    chk(bothCnt == 0, "R9", "read and write together", bothCnt, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule